// File: doc/BRIEF.md
# Physical Address Extender and Router

This block turns a processor-side address into a 22-bit physical address and decides which target receives the access. The processor is a 16-bit machine whose memory system is either 18 or 22 bits wide, as set by a strap input. Each request carries two things: the raw 16-bit program address, and a relocated address that external paging logic has already produced. A mode input chooses between direct addressing, 18-bit relocation and 22-bit relocation.

In every mode the top 8 KB of the address space (the I/O page) is lifted to the top of the physical space. How that happens depends on the mode and on the strap. The final address is then classified into one of three targets: main memory, the DMA remap window that exists only on 22-bit systems, or the peripheral bus for I/O page registers. The address and the target are registered together, one cycle after the request.

Top module: `paddr_router`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0, `pa` is 0 and `tgt` is 0.
- R2: `out_valid` rises one clock after a cycle in which `req_valid` is 1. `pa` and `tgt` describe that request. In any cycle where `out_valid` is 0, `tgt` is 0.
- R3: Mode 0 (direct) with `bus_wide`=0 maps `va` 160000–177777 (octal) to 760000–777777. Any other `va` is zero-extended. `reloc_addr` is ignored.
- R4: Mode 0 with `bus_wide`=1 maps `va` 160000–177777 to 17760000–17777777. Any other `va` is zero-extended.
- R5: Mode 1 (18-bit relocation) uses only `reloc_addr[17:0]`. With `bus_wide`=1, a value in 760000–777777 is extended to 17760000–17777777. Without the strap it stays where it is.
- R6: Mode 2 (22-bit relocation) with `bus_wide`=1 passes `reloc_addr` through unchanged. No I/O page extension is applied.
- R7: Mode 2 with `bus_wide`=0 behaves exactly like mode 1.
- R8: Mode 3 is reserved and behaves exactly like mode 0.
- R9: With `bus_wide`=1, the target is chosen from the physical address:
  - `tgt`=3'b100 (peripheral bus) for 17760000–17777777
  - `tgt`=3'b010 (DMA window) for 17000000–17757777
  - `tgt`=3'b001 (memory) for anything lower
- R10: With `bus_wide`=0, the target is chosen as follows, and the DMA window is never selected:
  - `tgt`=3'b100 for 760000–777777
  - `tgt`=3'b001 otherwise
- R11: With `bus_wide`=0, `pa[21:18]` is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| mode | input | 2 | 0 direct, 1 18-bit relocation, 2 22-bit relocation, 3 reserved |
| bus_wide | input | 1 | 1 = 22-bit physical system, 0 = 18-bit |
| va | input | 16 | Program address, used in direct mode |
| reloc_addr | input | 22 | Relocated address from the paging logic |
| out_valid | output | 1 | Registered result is valid |
| pa | output | 22 | Physical address |
| tgt | output | 3 | One-hot target: bit0 memory, bit1 DMA window, bit2 peripheral bus |

## Verification
Some properties are checked on every cycle:
- the one-cycle latency;
- `tgt` is one-hot when `out_valid` is 1 and zero when it is 0;
- pass-through in 22-bit relocation;
- no high address bits and no DMA-window selection on an 18-bit system;
- the peripheral-bus target is chosen only for I/O page addresses.

Only the bench's scenarios show the exact lifted address at each I/O page edge, in each mode and for each strap value. The same holds for the split between memory and the DMA window around 17000000 and 17757777, and for the reserved mode acting as direct.

// File: rtl/paddr_router.sv
module paddr_router #(
  parameter int VA_W   = 16,
  parameter int PA_W   = 22,
  parameter int NB_W   = 18,
  parameter int PAGE_W = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [1:0]      mode,
  input  logic            bus_wide,
  input  logic [VA_W-1:0] va,
  input  logic [PA_W-1:0] reloc_addr,
  output logic            out_valid,
  output logic [PA_W-1:0] pa,
  output logic [2:0]      tgt
);
  localparam logic [1:0] M_R18 = 2'd1;
  localparam logic [1:0] M_R22 = 2'd2;
  localparam int PAD_NB = NB_W - VA_W;
  localparam int PAD_PA = PA_W - NB_W;
  localparam int HI_NB  = NB_W - PAGE_W;
  localparam int HI_PA  = PA_W - PAGE_W;

  logic            use_r22, use_r18, va_io, nb_io;
  logic [NB_W-1:0] base;
  logic [PA_W-1:0] pa_c;
  logic [2:0]      tgt_c;

  assign use_r22 = (mode == M_R22) && bus_wide;
  assign use_r18 = (mode == M_R18) || ((mode == M_R22) && !bus_wide);
  assign va_io   = &va[VA_W-1:PAGE_W];

  always_comb begin
    if (use_r18)
      base = reloc_addr[NB_W-1:0];
    else if (va_io)
      base = {{HI_NB{1'b1}}, va[PAGE_W-1:0]};
    else
      base = {{PAD_NB{1'b0}}, va};
  end

  assign nb_io = &base[NB_W-1:PAGE_W];

  always_comb begin
    if (use_r22)
      pa_c = reloc_addr;
    else if (bus_wide && nb_io)
      pa_c = {{HI_PA{1'b1}}, base[PAGE_W-1:0]};
    else
      pa_c = {{PAD_PA{1'b0}}, base};
  end

  always_comb begin
    tgt_c = 3'b001;
    if (bus_wide) begin
      if (&pa_c[PA_W-1:PAGE_W])    tgt_c = 3'b100;
      else if (&pa_c[PA_W-1:NB_W]) tgt_c = 3'b010;
    end else if (&pa_c[NB_W-1:PAGE_W]) begin
      tgt_c = 3'b100;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      pa        <= '0;
      tgt       <= '0;
    end else begin
      out_valid <= req_valid;
      tgt       <= req_valid ? tgt_c : 3'b000;
      if (req_valid) pa <= pa_c;
    end
  end
endmodule

// File: rtl/paddr_router_chk.sv
module paddr_router_chk #(
  parameter int PA_W   = 22,
  parameter int NB_W   = 18,
  parameter int PAGE_W = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [1:0]      mode,
  input logic            bus_wide,
  input logic [PA_W-1:0] reloc_addr,
  input logic            out_valid,
  input logic [PA_W-1:0] pa,
  input logic [2:0]      tgt
);
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && tgt == 3'b000));
  p_tgt_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot(tgt));
  p_pass22_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bus_wide && mode == 2'd2) |=> pa == $past(reloc_addr));
  p_narrow_hi_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bus_wide) |=> pa[PA_W-1:NB_W] == '0);
  p_narrow_nodma_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bus_wide) |=> !tgt[1]);
  p_io_page_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && tgt[2]) |-> &pa[NB_W-1:PAGE_W]);
endmodule

bind paddr_router paddr_router_chk #(.PA_W(PA_W), .NB_W(NB_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
  .bus_wide(bus_wide), .reloc_addr(reloc_addr), .out_valid(out_valid),
  .pa(pa), .tgt(tgt)
);

// File: tb/sim_paddr_router.sv
`timescale 1ns/1ps
module sim_paddr_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        bus_wide = 1'b0;
  logic [15:0] va = '0;
  logic [21:0] reloc_addr = '0;
  logic        out_valid;
  logic [21:0] pa;
  logic [2:0]  tgt;

  int checks = 0;
  int failures = 0;
  logic [24:0] exp_q[$];
  string       tag_q[$];
  bit          wide_q[$];

  always #2 clk = ~clk;

  paddr_router u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
    .bus_wide(bus_wide), .va(va), .reloc_addr(reloc_addr),
    .out_valid(out_valid), .pa(pa), .tgt(tgt));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0o expected=%0o", req, act, expv);
    end
  endtask

  function automatic logic [24:0] model(input logic [1:0] m, input bit w,
                                        input logic [15:0] v, input logic [21:0] r);
    int unsigned a;
    logic [2:0] t;
    if (m == 2'd2 && w) a = r;
    else if (m == 2'd1 || m == 2'd2) begin
      a = r & 32'o777777;
      if (w && a >= 32'o760000) a = a - 32'o760000 + 32'o17760000;
    end else begin
      a = v;
      if (v >= 16'o160000) a = a - 32'o160000 + (w ? 32'o17760000 : 32'o760000);
    end
    if (w) t = (a >= 32'o17760000) ? 3'b100 : (a >= 32'o17000000) ? 3'b010 : 3'b001;
    else   t = (a >= 32'o760000) ? 3'b100 : 3'b001;
    return {a[21:0], t};
  endfunction

  function automatic string tag_of(input logic [1:0] m, input bit w);
    if (m == 2'd3) return "R8";
    if (m == 2'd1) return "R5";
    if (m == 2'd2) return w ? "R6" : "R7";
    return w ? "R4" : "R3";
  endfunction

  task automatic drive(input logic [1:0] m, input bit w, input logic [15:0] v, input logic [21:0] r);
    @(negedge clk);
    req_valid = 1'b1; mode = m; bus_wide = w; va = v; reloc_addr = r;
    exp_q.push_back(model(m, w, v, r));
    tag_q.push_back(tag_of(m, w));
    wide_q.push_back(w);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) check("R2", 1, 0);
      else begin
        logic [24:0] e;
        string tg;
        bit w;
        e = exp_q.pop_front(); tg = tag_q.pop_front(); w = wide_q.pop_front();
        check(tg, pa, e[24:3]);
        check(w ? "R9" : "R10", tgt, e[2:0]);
        if (!w) check("R11", pa[21:18], 0);
      end
    end
  end

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] vas[5];
    logic [21:0] ras[9];
    logic [31:0] lfsr;
    vas = '{16'o157777, 16'o160000, 16'o177777, 16'o000000, 16'o100000};
    ras = '{22'o17757777, 22'o17760000, 22'o17777777, 22'o17000000, 22'o16777777,
            22'o757777, 22'o760000, 22'o777777, 22'o13760000};
    repeat (3) @(negedge clk);
    check("R1", {out_valid, tgt}, 0);
    check("R1", pa, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {out_valid, tgt}, 0);
    for (int m = 0; m < 4; m++)
      for (int w = 0; w < 2; w++)
        for (int i = 0; i < 9; i++)
          drive(m[1:0], w[0], vas[i % 5], ras[i]);
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
    check("R2", {out_valid, tgt}, 0);
    check("R2", exp_q.size(), 0);
    lfsr = 32'hACE1_2468;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive(lfsr[1:0], lfsr[2], lfsr[18:3], {lfsr[31:22], lfsr[13:2]});
      if (lfsr[5]) begin
        @(negedge clk); req_valid = 1'b0;
      end
    end
    @(negedge clk); req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R2", exp_q.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule